// File: doc/BRIEF.md
# Bit-Plane Corner-Turn Engine

This block prepares data for a binary-code-modulated LED driver. A frame buffer outside the block holds one 32-bit brightness word per output channel, with the value right-aligned. A shift-out stage downstream does not want per-channel values. For every bit weight it wants one word in which bit j is channel j's bit of that weight. This engine performs that 32-by-32 corner turn. A parameter selects the window of source bits, so only the NBITS most significant bits of a MAX_BITS-wide brightness value become planes.

A one-cycle request pulse marks the frame as out of date by setting a pending flag. When the engine is idle and the flag is set, the flag clears and a conversion begins. The engine reads the frame buffer one word per clock through a read port with one cycle of latency. It gathers all planes in parallel registers. It then writes the finished planes, one per clock, into a small plane memory, which the shift-out stage reads through its own registered port. A request that arrives during a conversion is held in the flag, and a second conversion starts on the same edge that ends the current one. Several such requests merge into one follow-up conversion.

Top module: `bitplane_xpose`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o and pend_o are 0, and every plane word reads back as zero.
- R2: After a conversion, plane p (p = 0 .. NBITS-1) holds, at bit position j, bit (p + MAX_BITS - NBITS) of frame word j. Defaults: MAX_BITS = 16 and NBITS = 8, so plane p takes source bit p + 8.
- R3: Frame bits below position MAX_BITS - NBITS, and bits at or above position MAX_BITS, have no effect on any plane word.
- R4: A request sampled high sets pend_o on the next cycle. From idle, the next edge starts the conversion: busy_o rises and pend_o falls. A request in the same cycle as a start keeps pend_o set.
- R5: Each conversion asserts fb_rd_o for exactly 32 consecutive cycles. fb_addr_o runs 0, 1, ... 31 in ascending order, and the read data is taken one cycle after each address.
- R6: From idle, done_o is high for exactly one cycle, 34 + NBITS clock edges after the edge that samples the request. In that cycle the plane memory already holds the new planes.
- R7: If pend_o is set when the last plane is written, the next conversion starts on that same edge. busy_o stays high, and the next done_o comes 33 + NBITS edges later.
- R8: The plane read port returns the word at pl_rd_addr_i one cycle later. While a conversion is reading the frame buffer, the port still returns the previous conversion's planes.
- R9: Any number of requests during one conversion produce exactly one follow-up conversion. Afterwards busy_o returns to 0 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Frame-changed request pulse; sets the pending flag |
| fb_rd_o | output | 1 | Frame buffer read strobe |
| fb_addr_o | output | 5 | Frame buffer word address (channel index) |
| fb_data_i | input | 32 | Frame buffer read data, valid one cycle after the address |
| pl_rd_addr_i | input | 3 | Plane memory read index (bit weight) |
| pl_rd_data_o | output | 32 | Plane word, registered, one cycle after the index |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse: all planes of a conversion are written |
| pend_o | output | 1 | Pending (frame out of date) flag |

## Verification
The first result of a request is pend_o one edge after the sampling edge. busy_o follows one edge later. done_o follows 34 + NBITS edges after the sampling edge, or 33 + NBITS edges after a previous done_o when conversions run back to back. The bench drives at falling edges and counts falling edges from the request to the observed done_o, so a single cycle of drift in either direction shows up as a mismatch. Plane words are read two falling edges after the index is driven, to allow for the one register on the read port. A monitor records the length and address order of each frame-buffer read burst, and the bench compares the recorded values after each done_o.

// File: rtl/xpose_pkg.sv
// Shared types for the bit-plane corner-turn engine.
// Assumes: nothing beyond IEEE 1800-2017.
package xpose_pkg;

    // Conversion phases of the sequencer.
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,   // waiting for the pending flag
        XS_READ  = 2'd1,   // issuing one frame buffer read per cycle
        XS_FLUSH = 2'd2,   // absorbing the last read's latency
        XS_WRITE = 2'd3    // writing one plane per cycle
    } xpose_state_e;

endpackage

// File: rtl/xpose_seq.sv
// Sequencer: owns the pending flag, walks the frame buffer addresses,
// produces the capture strobe for the accumulator and the write strobe
// for the plane memory, and pulses done after the last plane write.
// Assumes: the frame buffer returns data exactly one cycle after the
// address is presented with the read strobe.
module xpose_seq
    import xpose_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int NBITS = 8,
    localparam int CW   = $clog2(NCH),
    localparam int PW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output logic          fb_rd_o,
    output logic [CW-1:0] fb_addr_o,
    output logic          cap_vld_o,
    output logic [CW-1:0] cap_idx_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          pend_o
);

    localparam logic [CW-1:0] LAST_RD = CW'(NCH - 1);
    localparam logic [PW-1:0] LAST_WR = PW'(NBITS - 1);

    xpose_state_e state_q, state_d;
    logic [CW-1:0] rd_idx_q;
    logic [PW-1:0] wr_idx_q;
    logic          pend_q;
    logic          cap_vld_q;
    logic [CW-1:0] cap_idx_q;
    logic          done_q;
    logic          last_rd, last_wr, start;

    assign last_rd = (rd_idx_q == LAST_RD);
    assign last_wr = (wr_idx_q == LAST_WR);

    // Purpose: a conversion begins from idle, or directly after the last plane write.
    assign start = pend_q && ((state_q == XS_IDLE) ||
                              (state_q == XS_WRITE && last_wr));

    // Purpose: next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (pend_q)  state_d = XS_READ;
            XS_READ:  if (last_rd) state_d = XS_FLUSH;
            XS_FLUSH:              state_d = XS_WRITE;
            XS_WRITE: if (last_wr) state_d = pend_q ? XS_READ : XS_IDLE;
            default:               state_d = XS_IDLE;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: pending flag; a new request wins over the clear at start.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (req_i)  pend_q <= 1'b1;
        else if (start)  pend_q <= 1'b0;
    end

    // Purpose: frame buffer address counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rd_idx_q <= '0;
        else if (start)                rd_idx_q <= '0;
        else if (state_q == XS_READ)   rd_idx_q <= rd_idx_q + 1'b1;
    end

    // Purpose: plane write counter, restarted on entry to the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wr_idx_q <= '0;
        else if (state_q == XS_FLUSH)  wr_idx_q <= '0;
        else if (state_q == XS_WRITE)  wr_idx_q <= wr_idx_q + 1'b1;
    end

    // Purpose: capture strobe aligned with the read data's one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_vld_q <= (state_q == XS_READ);
            cap_idx_q <= rd_idx_q;
        end
    end

    // Purpose: done pulse in the cycle after the last plane write.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == XS_WRITE) && last_wr;
    end

    assign fb_rd_o   = (state_q == XS_READ);
    assign fb_addr_o = rd_idx_q;
    assign cap_vld_o = cap_vld_q;
    assign cap_idx_o = cap_idx_q;
    assign wr_en_o   = (state_q == XS_WRITE);
    assign wr_idx_o  = wr_idx_q;
    assign busy_o    = (state_q != XS_IDLE);
    assign done_o    = done_q;
    assign pend_o    = pend_q;

    AST_DONE_AFTER_LAST_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(wr_en_o) && $past(wr_idx_q) == LAST_WR)); // R6
    AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(pend_q)) |-> (state_q == XS_READ)); // R7
    AST_WR_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> (wr_idx_q == '0 && !cap_vld_q)); // R2

endmodule

// File: rtl/xpose_acc.sv
// Plane accumulator: one register per bit weight, each NCH bits wide.
// Every captured frame word deposits its selected bit into column
// cap_idx_i of every plane at once. A read mux presents one plane
// for the plane memory write.
// Assumes: SKIP + NBITS <= WORD_W.
module xpose_acc #(
    parameter int NCH    = 32,
    parameter int WORD_W = 32,
    parameter int NBITS  = 8,
    parameter int SKIP   = 8,
    localparam int CW    = $clog2(NCH),
    localparam int PW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_vld_i,
    input  logic [CW-1:0]     cap_idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [PW-1:0]     rd_sel_i,
    output logic [NCH-1:0]    plane_o
);

    logic [NCH-1:0] planes [NBITS];

    // Bits outside the window are intentionally dropped.
    logic unused_word_bits;
    assign unused_word_bits = ^word_i;

    for (genvar p = 0; p < NBITS; p++) begin : g_plane
        logic [NCH-1:0] pl_q;

        // Purpose: deposit source bit (p + SKIP) of the captured word into column cap_idx_i.
        always_ff @(posedge clk) begin
            if (!rst_n)         pl_q <= '0;
            else if (cap_vld_i) pl_q[cap_idx_i] <= word_i[p + SKIP];
        end

        assign planes[p] = pl_q;
    end

    // Purpose: select the plane being written out.
    assign plane_o = planes[rd_sel_i];

endmodule

// File: rtl/xpose_plane_mem.sv
// Plane memory: NBITS words of NCH bits, one write port driven by the
// sequencer and one registered read port for the shift-out stage.
// A read and a write to the same index in one cycle return the old word.
// Assumes: the write index stays below NBITS.
module xpose_plane_mem #(
    parameter int NCH   = 32,
    parameter int NBITS = 8,
    localparam int PW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [PW-1:0]  wr_idx_i,
    input  logic [NCH-1:0] wr_data_i,
    input  logic [PW-1:0]  rd_idx_i,
    output logic [NCH-1:0] rd_data_o
);

    localparam logic [PW:0] DEPTH = (PW+1)'(NBITS);

    logic [NCH-1:0] mem_q [NBITS];
    logic [NCH-1:0] rd_q;

    // Purpose: storage with reset to all-zero planes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NBITS; k++) mem_q[k] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    // Purpose: registered read with an out-of-range guard.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rd_q <= '0;
        else if ({1'b0, rd_idx_i} < DEPTH) rd_q <= mem_q[rd_idx_i];
        else                              rd_q <= '0;
    end

    assign rd_data_o = rd_q;

    AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> ({1'b0, wr_idx_i} < DEPTH)); // R2

endmodule

// File: rtl/bitplane_xpose.sv
// Top of the bit-plane corner-turn engine. Connects the sequencer, the
// parallel plane accumulator and the plane memory.
// Assumes: NBITS <= MAX_BITS <= WORD_W, a frame buffer with one cycle of
// read latency, and a request that is a single-cycle pulse or level.
module bitplane_xpose #(
    parameter int NCH      = 32,
    parameter int WORD_W   = 32,
    parameter int MAX_BITS = 16,
    parameter int NBITS    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    output logic                          fb_rd_o,
    output logic [$clog2(NCH)-1:0]        fb_addr_o,
    input  logic [WORD_W-1:0]             fb_data_i,
    input  logic [((NBITS > 1) ? $clog2(NBITS) : 1)-1:0] pl_rd_addr_i,
    output logic [NCH-1:0]                pl_rd_data_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          pend_o
);

    localparam int CW   = $clog2(NCH);
    localparam int PW   = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int SKIP = MAX_BITS - NBITS;

    logic          cap_vld;
    logic [CW-1:0] cap_idx;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [NCH-1:0] wr_plane;

    xpose_seq #(
        .NCH   (NCH),
        .NBITS (NBITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .fb_rd_o   (fb_rd_o),
        .fb_addr_o (fb_addr_o),
        .cap_vld_o (cap_vld),
        .cap_idx_o (cap_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pend_o    (pend_o)
    );

    xpose_acc #(
        .NCH    (NCH),
        .WORD_W (WORD_W),
        .NBITS  (NBITS),
        .SKIP   (SKIP)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vld_i (cap_vld),
        .cap_idx_i (cap_idx),
        .word_i    (fb_data_i),
        .rd_sel_i  (wr_idx),
        .plane_o   (wr_plane)
    );

    xpose_plane_mem #(
        .NCH   (NCH),
        .NBITS (NBITS)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_plane),
        .rd_idx_i  (pl_rd_addr_i),
        .rd_data_o (pl_rd_data_o)
    );

    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pend_o); // R4
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && pend_o && !req_i) |=> (busy_o && !pend_o)); // R4
    AST_RD_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_rd_o) |-> (fb_addr_o == '0)); // R5
    AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd_o && fb_addr_o != CW'(NCH - 1)) |=> (fb_rd_o && fb_addr_o == $past(fb_addr_o) + 1'b1)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !fb_rd_o); // R5

endmodule

// File: tb/bitplane_xpose_test.sv
module bitplane_xpose_test;

    localparam int NCH      = 32;
    localparam int WORD_W   = 32;
    localparam int MAX_BITS = 16;
    localparam int NBITS    = 8;
    localparam int SKIP     = MAX_BITS - NBITS;
    localparam int PW       = $clog2(NBITS);
    localparam int LAT      = 34 + NBITS;
    localparam int GAP      = 33 + NBITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              fb_rd_o;
    logic [4:0]        fb_addr_o;
    logic [WORD_W-1:0] fb_data_i = '0;
    logic [PW-1:0]     pl_rd_addr_i = '0;
    logic [NCH-1:0]    pl_rd_data_o;
    logic              busy_o, done_o, pend_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [WORD_W-1:0] fb [NCH];
    logic [NCH-1:0]    saved [NBITS];

    always #4 clk = ~clk;

    bitplane_xpose #(
        .NCH(NCH), .WORD_W(WORD_W), .MAX_BITS(MAX_BITS), .NBITS(NBITS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .fb_rd_o(fb_rd_o), .fb_addr_o(fb_addr_o), .fb_data_i(fb_data_i),
        .pl_rd_addr_i(pl_rd_addr_i), .pl_rd_data_o(pl_rd_data_o),
        .busy_o(busy_o), .done_o(done_o), .pend_o(pend_o)
    );

    // Frame buffer model: one cycle of read latency.
    always @(posedge clk) if (fb_rd_o) fb_data_i <= fb[fb_addr_o];

    // Read-burst monitor for R5.
    int run_len = 0, last_run = 0, addr_err = 0;
    always @(negedge clk) begin
        if (fb_rd_o) begin
            if (int'(fb_addr_o) != run_len) addr_err++;
            run_len++;
        end else if (run_len != 0) begin
            last_run = run_len;
            run_len  = 0;
        end
    end

    function automatic logic [NCH-1:0] exp_plane(int p);
        logic [NCH-1:0] v;
        for (int j = 0; j < NCH; j++) v[j] = fb[j][p + SKIP];
        return v;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic read_plane(int p, output logic [NCH-1:0] v);
        @(negedge clk) pl_rd_addr_i = PW'(p);
        @(negedge clk) v = pl_rd_data_o;
    endtask

    task automatic check_planes(string rq);
        logic [NCH-1:0] v;
        for (int p = 0; p < NBITS; p++) begin
            read_plane(p, v);
            chk(rq, $sformatf("plane %0d", p), v, exp_plane(p));
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
    endtask

    // One conversion from idle with flag, latency (R4, R6) and burst (R5) checks.
    task automatic run_conv();
        int k;
        pulse_req();
        chk("R4", "pend after request", {31'd0, pend_o}, 32'd1);
        chk("R4", "busy before start", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        k = 1;
        chk("R4", "busy at start", {31'd0, busy_o}, 32'd1);
        chk("R4", "pend cleared at start", {31'd0, pend_o}, 32'd0);
        while (!done_o && k < 500) begin
            @(negedge clk);
            k++;
        end
        chk("R6", "done latency", k, LAT);
        @(negedge clk);
        chk("R6", "done one cycle", {31'd0, done_o}, 32'd0);
        chk("R5", "read burst length", last_run, 32);
        chk("R5", "read address order errors", addr_err, 0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [NCH-1:0] v;
        int unsigned seed;
        int k;
        seed = $urandom(32'd7321);
        for (int j = 0; j < NCH; j++) fb[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
        chk("R1", "done after reset", {31'd0, done_o}, 32'd0);
        chk("R1", "pend after reset", {31'd0, pend_o}, 32'd0);
        for (int p = 0; p < NBITS; p++) begin
            read_plane(p, v);
            chk("R1", $sformatf("plane %0d after reset", p), v, 32'd0);
        end

        // R2: all ones
        for (int j = 0; j < NCH; j++) fb[j] = 32'hFFFF_FFFF;
        run_conv();
        check_planes("R2");

        // R3: only bits outside the window set -> all planes zero
        for (int j = 0; j < NCH; j++)
            fb[j] = $urandom & ~(((32'd1 << NBITS) - 1) << SKIP);
        run_conv();
        for (int p = 0; p < NBITS; p++) begin
            read_plane(p, v);
            chk("R3", $sformatf("outside-window plane %0d", p), v, 32'd0);
        end

        // R2: walking pattern, channel j holds brightness j at the window
        for (int j = 0; j < NCH; j++) fb[j] = (32'(j) << SKIP) | 32'hFFFF_0000;
        run_conv();
        check_planes("R2");

        // R2, R3: random frames
        for (int it = 0; it < 12; it++) begin
            for (int j = 0; j < NCH; j++) fb[j] = $urandom;
            run_conv();
            check_planes("R2");
        end

        // R8: old planes visible while the next conversion reads
        for (int p = 0; p < NBITS; p++) saved[p] = exp_plane(p);
        for (int j = 0; j < NCH; j++) fb[j] = $urandom;
        pulse_req();
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            read_plane(p, v);
            chk("R8", $sformatf("old plane %0d during read", p), v, saved[p]);
        end
        k = 0;
        while (!done_o && k < 500) begin @(negedge clk); k++; end
        check_planes("R8");

        // R7, R9: requests during a conversion chain into one follow-up
        for (int j = 0; j < NCH; j++) fb[j] = $urandom;
        pulse_req();
        repeat (4) @(negedge clk);
        pulse_req();
        repeat (3) @(negedge clk);
        pulse_req();
        k = 0;
        while (!done_o && k < 500) begin @(negedge clk); k++; end
        chk("R7", "busy at first done", {31'd0, busy_o}, 32'd1);
        chk("R7", "pend cleared at chained start", {31'd0, pend_o}, 32'd0);
        k = 0;
        @(negedge clk);
        k = 1;
        while (!done_o && k < 500) begin @(negedge clk); k++; end
        chk("R7", "done-to-done gap", k, GAP);
        chk("R9", "idle after follow-up", {31'd0, busy_o}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R9", "no third conversion busy", {31'd0, busy_o}, 32'd0);
        chk("R9", "no third conversion pend", {31'd0, pend_o}, 32'd0);
        check_planes("R7");

        // R4: request in the start cycle keeps the flag
        @(negedge clk) req_i = 1'b1;
        @(negedge clk);
        @(negedge clk) req_i = 1'b0;
        chk("R4", "flag kept on start-cycle request", {31'd0, pend_o}, 32'd1);
        chk("R4", "busy with kept flag", {31'd0, busy_o}, 32'd1);
        k = 0;
        while (!done_o && k < 500) begin @(negedge clk); k++; end
        chk("R7", "chained after start-cycle request", {31'd0, busy_o}, 32'd1);
        k = 0;
        while (busy_o && k < 500) begin @(negedge clk); k++; end
        check_planes("R2");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule